// File: doc/BRIEF.md
# Dual-Address Transfer Sequence Generator

This block produces the address pair for each element of a frame that moves data between a timer coprocessor's instruction RAM and main memory. A control word sets the direction, the element width, how each address steps and the starting timer-RAM address. The starting main-memory address and the number of elements per frame come in on ports. A frame-start pulse captures the control settings and loads both working addresses. Each element-done pulse then moves the two addresses forward, each by its own stride. The block presents the read address, the write address and the element width for the element now due.

The two address streams are independent. The timer-side address steps by 16 bytes, which lands on the same field of the next instruction, or by 8 bytes, which walks through adjacent field pairs. The memory-side address either stays fixed or advances by the element width. The direction setting decides which of the two addresses is read and which is written.

When the programmed number of elements is done, the block pulses frame completion. Circular mode then reloads both addresses and keeps running. The other modes stop and raise a done flag. Data movement, bus protocol, arbitration and switching between buffers are handled elsewhere.

Top module: `xfer_addr_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `frame_done_o` are 0, both address outputs are 0, `size64_o` is 0 and `cfg_rdata_o` is 0.
- R2: A write with `cfg_we_i` and `cfg_priv_i` both high stores the control word, and `cfg_rdata_o` shows it from the next cycle. The control word has these fields:
  - bit 23: direction
  - bit 22: size
  - bit 21: timer stride
  - bit 20: memory hold
  - bits 19:18: buffer-A mode
  - bits 17:16: buffer-B mode
  - bits 12:2: initial timer word address

  Bits 31:24, 15:13 and 1:0 always read 0.
- R3: A write with `cfg_priv_i` low leaves `cfg_rdata_o` and all later behaviour unchanged.
- R4: `frame_start_i` loads the timer address with `cfg[12:2]` followed by two zero bits. It loads the memory address with `mem_init_i`, raises `busy_o` and clears `done_o`. The 13-bit timer address always has its two low bits at 0.
- R5: With the direction bit at 0, `rd_addr_o` is the zero-extended timer address and `wr_addr_o` is the memory address. With the direction bit at 1, the two are swapped.
- R6: `size64_o` equals the size bit captured at frame start: 0 means 32-bit elements and 1 means 64-bit elements.
- R7: Each accepted element-done pulse that does not end the frame adds 16 (timer stride bit 0) or 8 (timer stride bit 1) to the timer address, modulo 2^13.
- R8: On the same event, a memory hold bit of 0 adds 4 to the memory address for 32-bit elements or 8 for 64-bit elements, modulo 2^MEM_AW. A memory hold bit of 1 keeps the memory address constant for the whole frame.
- R9: The element-done pulse that completes `elem_cnt_i` elements (sampled at frame start; 0 counts as 1) makes `frame_done_o` high for exactly the next cycle.
- R10: At frame completion, buffer-A mode 1 (circular) reloads both initial addresses and stays busy. Modes 0, 2 and 3 drop `busy_o`, keep the addresses, and hold `done_o` high until the next frame start.
- R11: `elem_done_i` is ignored while `busy_o` is low. Control writes made during a frame take effect only at the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_priv_i | input | 1 | Write privilege qualifier |
| cfg_wdata_i | input | 32 | Control word write data |
| cfg_rdata_o | output | 32 | Stored control word, reserved bits zero |
| mem_init_i | input | MEM_AW | Initial main-memory address, sampled at frame start |
| elem_cnt_i | input | CNT_W | Elements per frame, sampled at frame start |
| frame_start_i | input | 1 | Starts a frame and loads the addresses |
| elem_done_i | input | 1 | Current element finished |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | Non-circular frame completed |
| frame_done_o | output | 1 | One-cycle frame completion pulse |
| rd_addr_o | output | MEM_AW | Read address of the current element |
| wr_addr_o | output | MEM_AW | Write address of the current element |
| size64_o | output | 1 | Element width: 0 is 32-bit, 1 is 64-bit |

## Verification
The bench builds the block with MEM_AW = 20 and CNT_W = 6. The narrow memory address keeps the zero-extension of the timer address into the wider read and write ports visible. The 6-bit count gives short frames, so one run can cover one-shot, circular and hold modes, a zero element count, and a timer address that wraps past 0x1FF8. The expected addresses come from a step-by-step model of the requirements, compared element by element.

// File: rtl/xfer_seq_pkg.sv
package xfer_seq_pkg;
  localparam int CFG_W       = 32;
  localparam int TMR_AW      = 13;
  localparam int TINIT_LSB   = 2;
  localparam int TINIT_W     = TMR_AW - TINIT_LSB;
  localparam int DIR_BIT     = 23;
  localparam int SIZE_BIT    = 22;
  localparam int TSTEP_BIT   = 21;
  localparam int MHOLD_BIT   = 20;
  localparam int MODEA_LSB   = 18;
  localparam int MODEB_LSB   = 16;
  localparam logic [CFG_W-1:0] CFG_RW_MASK = 32'h00FF_1FFC;

  typedef enum logic [1:0] {
    BUF_ONESHOT = 2'd0,
    BUF_CIRC    = 2'd1,
    BUF_AUTO_0  = 2'd2,
    BUF_AUTO_1  = 2'd3
  } buf_mode_e;

  typedef struct packed {
    logic              dir;
    logic              size64;
    logic              tmr_step8;
    logic              mem_hold;
    buf_mode_e         mode_a;
    buf_mode_e         mode_b;
    logic [TINIT_W-1:0] tinit;
  } xfer_cfg_t;
endpackage

// File: rtl/xfer_cfg_reg.sv
module xfer_cfg_reg
  import xfer_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             priv_i,
  input  logic [CFG_W-1:0] wdata_i,
  output xfer_cfg_t        cfg_o,
  output logic [CFG_W-1:0] rdata_o
);
  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cfg_q <= '0;
    else if (we_i && priv_i)   cfg_q <= wdata_i & CFG_RW_MASK;
  end

  assign rdata_o          = cfg_q;
  assign cfg_o.dir        = cfg_q[DIR_BIT];
  assign cfg_o.size64     = cfg_q[SIZE_BIT];
  assign cfg_o.tmr_step8  = cfg_q[TSTEP_BIT];
  assign cfg_o.mem_hold   = cfg_q[MHOLD_BIT];
  assign cfg_o.mode_a     = buf_mode_e'(cfg_q[MODEA_LSB +: 2]);
  assign cfg_o.mode_b     = buf_mode_e'(cfg_q[MODEB_LSB +: 2]);
  assign cfg_o.tinit      = cfg_q[TINIT_LSB +: TINIT_W];

  AST_NOPRIV_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !priv_i) |=> $stable(rdata_o)); // R3
endmodule

// File: rtl/xfer_addr_ctr.sv
module xfer_addr_ctr #(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          adv_i,
  input  logic [AW-1:0] step_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q;

  // load wins over advance; sum wraps modulo 2^AW
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (load_i) addr_q <= load_val_i;
    else if (adv_i)  addr_q <= addr_q + step_i;
  end

  assign addr_o = addr_q;

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv_i) |=> $stable(addr_o)); // R11
endmodule

// File: rtl/xfer_frame_ctl.sv
module xfer_frame_ctl #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             edone_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             circ_i,
  output logic             adv_o,
  output logic             reload_o,
  output logic             active_o,
  output logic             done_o,
  output logic             frame_done_o
);
  localparam int IW = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q, idx_q;
  logic             active_q, done_q, fdone_q;
  logic             accept, last;
  logic [IW-1:0]    idx_next;

  assign accept   = edone_i && active_q && !start_i;
  assign idx_next = {1'b0, idx_q} + IW'(1);
  assign last     = accept && (idx_next >= {1'b0, cnt_q}); // count 0 acts as 1
  assign adv_o    = accept && !last;
  assign reload_o = last && circ_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      idx_q    <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
      fdone_q  <= 1'b0;
    end else begin
      fdone_q <= last;
      if (start_i) begin
        cnt_q    <= count_i;
        idx_q    <= '0;
        active_q <= 1'b1;
        done_q   <= 1'b0;
      end else if (last) begin
        idx_q <= '0;
        if (!circ_i) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end
      end else if (adv_o) begin
        idx_q <= idx_next[CNT_W-1:0];
      end
    end
  end

  assign active_o     = active_q;
  assign done_o       = done_q;
  assign frame_done_o = fdone_q;

  AST_DONE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(active_q && done_q)); // R10
  AST_IDLE_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_q && !start_i) |=> !active_q); // R11
endmodule

// File: rtl/xfer_addr_seq.sv
module xfer_addr_seq
  import xfer_seq_pkg::*;
#(
  parameter int MEM_AW = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_priv_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  output logic [CFG_W-1:0]  cfg_rdata_o,
  input  logic [MEM_AW-1:0] mem_init_i,
  input  logic [CNT_W-1:0]  elem_cnt_i,
  input  logic              frame_start_i,
  input  logic              elem_done_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              frame_done_o,
  output logic [MEM_AW-1:0] rd_addr_o,
  output logic [MEM_AW-1:0] wr_addr_o,
  output logic              size64_o
);
  localparam int TPAD = MEM_AW - TMR_AW;

  xfer_cfg_t         cfg, snap_q;
  logic [MEM_AW-1:0] mem_init_q, mem_addr, mem_step, mem_load_val;
  logic [TMR_AW-1:0] tmr_addr, tmr_step, tmr_init;
  logic              adv, reload, load;

  xfer_cfg_reg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .priv_i  (cfg_priv_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg),
    .rdata_o (cfg_rdata_o)
  );

  // settings frozen for the whole frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q     <= '0;
      mem_init_q <= '0;
    end else if (frame_start_i) begin
      snap_q     <= cfg;
      mem_init_q <= mem_init_i;
    end
  end

  xfer_frame_ctl #(.CNT_W(CNT_W)) u_frame (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (frame_start_i),
    .edone_i      (elem_done_i),
    .count_i      (elem_cnt_i),
    .circ_i       (snap_q.mode_a == BUF_CIRC),
    .adv_o        (adv),
    .reload_o     (reload),
    .active_o     (busy_o),
    .done_o       (done_o),
    .frame_done_o (frame_done_o)
  );

  assign load         = frame_start_i || reload;
  assign tmr_init     = frame_start_i ? {cfg.tinit, 2'b00} : {snap_q.tinit, 2'b00};
  assign mem_load_val = frame_start_i ? mem_init_i : mem_init_q;
  assign tmr_step     = snap_q.tmr_step8 ? TMR_AW'(8) : TMR_AW'(16);
  assign mem_step     = snap_q.mem_hold ? '0 : (snap_q.size64 ? MEM_AW'(8) : MEM_AW'(4));

  xfer_addr_ctr #(.AW(TMR_AW)) u_tmr_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (tmr_init),
    .adv_i      (adv),
    .step_i     (tmr_step),
    .addr_o     (tmr_addr)
  );

  xfer_addr_ctr #(.AW(MEM_AW)) u_mem_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (mem_load_val),
    .adv_i      (adv),
    .step_i     (mem_step),
    .addr_o     (mem_addr)
  );

  generate
    if (TPAD > 0) begin : g_pad
      logic [MEM_AW-1:0] tmr_ext;
      assign tmr_ext   = {{TPAD{1'b0}}, tmr_addr};
      assign rd_addr_o = snap_q.dir ? mem_addr : tmr_ext;
      assign wr_addr_o = snap_q.dir ? tmr_ext  : mem_addr;
    end else begin : g_nopad
      assign rd_addr_o = snap_q.dir ? mem_addr : MEM_AW'(tmr_addr);
      assign wr_addr_o = snap_q.dir ? MEM_AW'(tmr_addr) : mem_addr;
    end
  endgenerate

  assign size64_o = snap_q.size64;

  AST_TMR_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_addr[1:0] == 2'b00); // R4
  AST_MEM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && snap_q.mem_hold && !frame_start_i) |=> $stable(mem_addr)); // R8
  AST_DONE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> frame_done_o); // R10
endmodule

// File: tb/xfer_addr_seq_tb_top.sv
module xfer_addr_seq_tb_top;
  localparam int MEM_AW = 20;
  localparam int CNT_W  = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0, cfg_priv = 1'b0;
  logic [31:0]       cfg_wdata = '0, cfg_rdata;
  logic [MEM_AW-1:0] mem_init = '0, rd_addr, wr_addr;
  logic [CNT_W-1:0]  elem_cnt = '0;
  logic              frame_start = 1'b0, elem_done = 1'b0;
  logic              busy, done, frame_done, size64;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  xfer_addr_seq #(.MEM_AW(MEM_AW), .CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_priv_i(cfg_priv), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata), .mem_init_i(mem_init), .elem_cnt_i(elem_cnt),
    .frame_start_i(frame_start), .elem_done_i(elem_done),
    .busy_o(busy), .done_o(done), .frame_done_o(frame_done),
    .rd_addr_o(rd_addr), .wr_addr_o(wr_addr), .size64_o(size64)
  );

  typedef struct {
    logic [MEM_AW-1:0] rd, wr;
    logic              sz, bsy, dn, fd;
    logic [31:0]       rdata;
    string             tag;
  } exp_t;

  exp_t exp_q[$];

  // requirement model
  logic [31:0]       m_cfg = '0;
  logic              s_dir = 0, s_sz = 0, s_t8 = 0, s_hold = 0, s_circ = 0;
  logic [12:0]       s_tinit = '0, m_tmr = '0;
  logic [MEM_AW-1:0] s_minit = '0, m_mem = '0;
  int                s_cnt = 0, m_idx = 0;
  logic              m_act = 0, m_done = 0, m_fd = 0;

  function automatic void model_step(logic we, logic pv, logic [31:0] wd, logic st,
                                     logic [MEM_AW-1:0] mi, int cnt, logic ed);
    m_fd = 1'b0;
    if (st) begin
      s_dir = m_cfg[23]; s_sz = m_cfg[22]; s_t8 = m_cfg[21]; s_hold = m_cfg[20];
      s_circ = (m_cfg[19:18] == 2'd1);
      s_tinit = {m_cfg[12:2], 2'b00};
      s_minit = mi; s_cnt = cnt; m_idx = 0;
      m_tmr = s_tinit; m_mem = mi; m_act = 1'b1; m_done = 1'b0;
    end else if (ed && m_act) begin
      if (m_idx + 1 >= s_cnt) begin
        m_fd = 1'b1; m_idx = 0;
        if (s_circ) begin m_tmr = s_tinit; m_mem = s_minit; end
        else begin m_act = 1'b0; m_done = 1'b1; end
      end else begin
        m_idx++;
        m_tmr = m_tmr + (s_t8 ? 13'd8 : 13'd16);
        m_mem = m_mem + (s_hold ? MEM_AW'(0) : (s_sz ? MEM_AW'(8) : MEM_AW'(4)));
      end
    end
    if (we && pv) m_cfg = wd & 32'h00FF_1FFC;
  endfunction

  task automatic drive(logic we, logic pv, logic [31:0] wd, logic st,
                       logic [MEM_AW-1:0] mi, int cnt, logic ed, string tag);
    exp_t e;
    logic [MEM_AW-1:0] t_ext;
    @(negedge clk);
    cfg_we = we; cfg_priv = pv; cfg_wdata = wd; frame_start = st;
    mem_init = mi; elem_cnt = CNT_W'(cnt); elem_done = ed;
    @(posedge clk);
    #1;
    model_step(we, pv, wd, st, mi, cnt, ed);
    t_ext   = MEM_AW'(m_tmr);
    e.rd    = s_dir ? m_mem : t_ext;
    e.wr    = s_dir ? t_ext : m_mem;
    e.sz    = s_sz; e.bsy = m_act; e.dn = m_done; e.fd = m_fd;
    e.rdata = m_cfg; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle(string tag);
    drive(1'b0, 1'b0, '0, 1'b0, '0, 0, 1'b0, tag);
  endtask

  task automatic edone(string tag);
    drive(1'b0, 1'b0, '0, 1'b0, '0, 0, 1'b1, tag);
  endtask

  task automatic wcfg(logic pv, logic [31:0] wd, string tag);
    drive(1'b1, pv, wd, 1'b0, '0, 0, 1'b0, tag);
  endtask

  task automatic start(logic [MEM_AW-1:0] mi, int cnt, string tag);
    drive(1'b0, 1'b0, '0, 1'b1, mi, cnt, 1'b0, tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (rd_addr !== e.rd || wr_addr !== e.wr || size64 !== e.sz || busy !== e.bsy ||
            done !== e.dn || frame_done !== e.fd || cfg_rdata !== e.rdata) begin
          errors++;
          $display("FAIL %s: got rd=%h wr=%h sz=%b busy=%b done=%b fd=%b cfg=%h exp rd=%h wr=%h sz=%b busy=%b done=%b fd=%b cfg=%h",
                   e.tag, rd_addr, wr_addr, size64, busy, done, frame_done, cfg_rdata,
                   e.rd, e.wr, e.sz, e.bsy, e.dn, e.fd, e.rdata);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++; // R1 reset state
    if (busy !== 0 || done !== 0 || frame_done !== 0 || rd_addr !== '0 ||
        wr_addr !== '0 || size64 !== 0 || cfg_rdata !== '0) begin
      errors++;
      $display("FAIL R1: got busy=%b done=%b rd=%h cfg=%h exp all zero", busy, done, rd_addr, cfg_rdata);
    end
    rst_n = 1'b1;
    idle("R1");
    // R2: reserved bits read 0
    wcfg(1'b1, 32'hFFFF_FFFF, "R2");
    idle("R2");
    // R3: unprivileged write dropped
    wcfg(1'b0, 32'h0000_0000, "R3");
    idle("R3");
    // R4/R7/R8/R9/R10: dir0, 32-bit, stride 16, post-increment, one-shot
    wcfg(1'b1, 32'h0000_0100, "R2");
    start(MEM_AW'('h4000), 3, "R4");
    edone("R7 R8");
    idle("R7");
    edone("R7 R8");
    edone("R9 R10 one-shot");
    idle("R9 pulse ends");
    // R11: element done while idle ignored
    edone("R11 idle");
    idle("R11");
    // R5/R6/R7 wrap/R10 circular: dir1, 64-bit, stride 8, init 0x1FF8
    wcfg(1'b1, 32'h00E4_1FF8, "R2");
    start(MEM_AW'('hFFFF8), 2, "R4 R5 R6");
    edone("R7 wrap R8 64-bit");
    edone("R10 circular reload");
    edone("R7 R8");
    // R11: write mid-frame has no effect until next start
    wcfg(1'b1, 32'h0080_0000, "R11");
    edone("R11 R10");
    edone("R11");
    // R8 hold, R9 count zero, R10 auto mode stops
    wcfg(1'b1, 32'h0018_0040, "R2");
    start(MEM_AW'('h01230), 0, "R4 R8");
    edone("R9 count0 R10 mode2");
    idle("R10 done held");
    wcfg(1'b1, 32'h0018_0040, "R2");
    start(MEM_AW'('h00010), 4, "R8 hold");
    edone("R8 hold");
    edone("R8 hold");
    start(MEM_AW'('h00020), 2, "R4 restart");
    edone("R7");
    edone("R9 R10");
    idle("end");
    idle("end");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule